// File: doc/BRIEF.md
# Buffered PWM Compare Timer Channel

This block is one up-counting timer channel that drives a pulse-width-modulated output. A counter advances on every cycle in which the clock enable is high. It returns to zero after the cycle in which it equals a period register. A compare register B sets the falling point of the waveform. An optional second compare register E exists only on the full channel variant.

Each compare register has a shadow buffer. Software may rewrite the buffer at any time without disturbing the current period. The buffer is copied into its compare register at one of two moments, chosen by a timing-select bit in an 8-bit transfer-mode register. The first choice is the cycle in which that compare register matches the counter. The second choice is the counter-clear at the end of the period, which is allowed only while PWM mode is on.

All registers sit behind one word-wide write port and one combinational read port. Outputs are the PWM pin and a compare-match strobe for register B.

Top module: `pwm_buf_timer`

## Requirements
- R1: After reset the counter reads 0. The control and transfer-mode registers read 0. The period, compare and buffer registers read 16'hFFFF. `pwm_out` is 0.
- R2: The transfer-mode register is at address 7. Bit 1 selects the B-pair timing and bit 2 selects the E-pair timing. Bits 7..3, and all upper bits of `rd_data`, always read 0 whatever was written.
- R3: When `HAS_E` is 0, transfer-mode bit 2 reads 0 and ignores writes, and the E compare address (4) and E buffer address (5) read 0.
- R4: The counter (address 0) increases by 1 on each edge where `cnt_en` is high. On the edge where it equals the period (address 1), it becomes 0 instead. It holds its value while `cnt_en` is low. A write to address 0 loads it directly.
- R5: The control register is at address 6: bit 0 is PWM mode and bit 1 is buffer enable B. With buffer enable B set and timing bit 1 at 0, buffer D (address 3) is copied into compare B (address 2) at the edge that ends an enabled cycle in which the counter equals compare B.
- R6: With buffer enable B, timing bit 1 set and PWM mode on, compare B does not change on its match. It loads buffer D at the counter-clear edge.
- R7: The E pair (compare at address 4, buffer at address 5, buffer enable in control bit 2) follows the same rules as the B pair, using transfer-mode bit 2.
- R8: While PWM mode is off, a timing-select bit of 1 acts as 0, so the transfer happens on compare match.
- R9: With a pair's buffer enable clear, a write to its compare address changes the compare register directly. With the buffer enable set, such a write lands in the buffer and the compare register keeps its value.
- R10: If a buffer write and a transfer fall in the same cycle, the compare register receives the old buffer value and the buffer keeps the newly written value.
- R11: In PWM mode, with period P and a fixed compare B value C, `pwm_out` is high for C+1 of every P+1 enabled cycles when 1 <= C < P. It is always low when C = 0 and always high when C >= P. Outside PWM mode `pwm_out` is 0.
- R12: `cmp_flag` is high during each cycle in which `cnt_en` is high and the counter equals compare B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Count enable; gates all count, match and clear events |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data (mode registers use the low 8 bits) |
| rd_addr | input | 3 | Register read address |
| rd_data | output | CNT_W | Combinational read data |
| pwm_out | output | 1 | PWM waveform |
| cmp_flag | output | 1 | Compare-match B strobe |

## Verification
On every cycle, the in-RTL assertions check several behaviours:
- the counter wraps at the period and holds while disabled;
- a transfer always delivers the buffer value from before the edge;
- compare B holds through a match when clear-timing is active;
- the select bit falls back to match-timing outside PWM mode;
- compare-address writes are routed either directly or into the buffer;
- the output stays low outside PWM mode.

Only the bench's scenarios can show the rest:
- the duty-cycle counts over whole periods for different period and compare values;
- reserved-bit read-back;
- the reduced variant without the E pair;
- reset values;
- the exact cycle of the match strobe.

// File: rtl/pwmbt_pkg.sv
package pwmbt_pkg;
  typedef enum logic [2:0] {
    RA_CNT   = 3'd0,
    RA_PER   = 3'd1,
    RA_CMPB  = 3'd2,
    RA_BUFB  = 3'd3,
    RA_CMPE  = 3'd4,
    RA_BUFE  = 3'd5,
    RA_CTRL  = 3'd6,
    RA_XMODE = 3'd7
  } reg_addr_e;

  localparam int CTRL_PWM  = 0;
  localparam int CTRL_BUFB = 1;
  localparam int CTRL_BUFE = 2;
  localparam int XM_SELB   = 1;
  localparam int XM_SELE   = 2;

  function automatic logic [7:0] xmode_mask(input bit has_e);
    return has_e ? 8'h06 : 8'h02;
  endfunction

  function automatic logic [2:0] ctrl_mask(input bit has_e);
    return has_e ? 3'b111 : 3'b011;
  endfunction
endpackage

// File: rtl/pwmbt_counter.sv
module pwmbt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt_q,
  output logic             clear_evt
);
  assign clear_evt = cnt_en && (cnt_q == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (wr_cnt)    cnt_q <= wr_data;
    else if (clear_evt) cnt_q <= '0;
    else if (cnt_en)    cnt_q <= cnt_q + 1'b1;
  end

  assert_wrap_at_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_evt && !wr_cnt) |=> (cnt_q == '0));
  assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !wr_cnt) |=> $stable(cnt_q));
endmodule

// File: rtl/pwmbt_buf_pair.sv
module pwmbt_buf_pair #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] cnt,
  input  logic             clear_evt,
  input  logic             pwm_mode,
  input  logic             buf_en,
  input  logic             sel_clear,
  input  logic             wr_cmp,
  input  logic             wr_buf,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cmp_q,
  output logic [CNT_W-1:0] buf_q,
  output logic             hit,
  output logic             xfer
);
  logic eff_sel;

  assign hit     = cnt_en && (cnt == cmp_q);
  assign eff_sel = sel_clear && pwm_mode;
  assign xfer    = buf_en && (eff_sel ? clear_evt : hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '1;
      buf_q <= '1;
    end else begin
      if (xfer)                 cmp_q <= buf_q;
      else if (wr_cmp && !buf_en) cmp_q <= wr_data;
      if (wr_buf || (wr_cmp && buf_en)) buf_q <= wr_data;
    end
  end

  assert_xfer_old_buffer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (cmp_q == $past(buf_q)));
  assert_clear_mode_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && sel_clear && pwm_mode && !clear_evt) |=> $stable(cmp_q));
  assert_non_pwm_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_mode && buf_en && hit) |=> (cmp_q == $past(buf_q)));
  assert_direct_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_en && wr_cmp) |=> (cmp_q == $past(wr_data)));
  assert_redirect_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && wr_cmp) |=> (buf_q == $past(wr_data)));
endmodule

// File: rtl/pwmbt_wave.sv
module pwmbt_wave #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_mode,
  input  logic             clear_evt,
  input  logic             hit_b,
  input  logic             xfer_b,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic [CNT_W-1:0] buf_b,
  output logic             pwm_q
);
  function automatic logic level_after_clear(input logic [CNT_W-1:0] next_cmp);
    return next_cmp != '0;
  endfunction

  logic [CNT_W-1:0] next_cmp;
  assign next_cmp = xfer_b ? buf_b : cmp_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        pwm_q <= 1'b0;
    else if (!pwm_mode)                pwm_q <= 1'b0;
    else if (clear_evt)                pwm_q <= level_after_clear(next_cmp);
    else if (hit_b && (cmp_b != '0))   pwm_q <= 1'b0;
  end

  assert_low_outside_pwm_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_mode |=> !pwm_q);
  assert_zero_duty_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && clear_evt && (next_cmp == '0)) |=> !pwm_q);
endmodule

// File: rtl/pwm_buf_timer.sv
module pwm_buf_timer #(
  parameter int CNT_W = 16,
  parameter bit HAS_E = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             pwm_out,
  output logic             cmp_flag
);
  import pwmbt_pkg::*;

  localparam logic [7:0] XM_MASK = xmode_mask(HAS_E);
  localparam logic [2:0] CT_MASK = ctrl_mask(HAS_E);

  logic [CNT_W-1:0] per_q, cnt_q, cmp_b, buf_b, cmp_e, buf_e;
  logic [2:0]       ctrl_q;
  logic [7:0]       xmode_q;
  logic             clear_evt, hit_b, xfer_b;
  logic             wr_cnt, wr_per, wr_cmpb, wr_bufb, wr_cmpe, wr_bufe;
  logic             wr_ctrl, wr_xmode;

  assign wr_cnt   = wr_en && (wr_addr == RA_CNT);
  assign wr_per   = wr_en && (wr_addr == RA_PER);
  assign wr_cmpb  = wr_en && (wr_addr == RA_CMPB);
  assign wr_bufb  = wr_en && (wr_addr == RA_BUFB);
  assign wr_cmpe  = wr_en && (wr_addr == RA_CMPE);
  assign wr_bufe  = wr_en && (wr_addr == RA_BUFE);
  assign wr_ctrl  = wr_en && (wr_addr == RA_CTRL);
  assign wr_xmode = wr_en && (wr_addr == RA_XMODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q   <= '1;
      ctrl_q  <= '0;
      xmode_q <= '0;
    end else begin
      if (wr_per)   per_q   <= wr_data;
      if (wr_ctrl)  ctrl_q  <= wr_data[2:0] & CT_MASK;
      if (wr_xmode) xmode_q <= wr_data[7:0] & XM_MASK;
    end
  end

  pwmbt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_cnt(wr_cnt),
    .wr_data(wr_data), .period(per_q), .cnt_q(cnt_q), .clear_evt(clear_evt)
  );

  pwmbt_buf_pair #(.CNT_W(CNT_W)) u_pair_b (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt(cnt_q),
    .clear_evt(clear_evt), .pwm_mode(ctrl_q[CTRL_PWM]),
    .buf_en(ctrl_q[CTRL_BUFB]), .sel_clear(xmode_q[XM_SELB]),
    .wr_cmp(wr_cmpb), .wr_buf(wr_bufb), .wr_data(wr_data),
    .cmp_q(cmp_b), .buf_q(buf_b), .hit(hit_b), .xfer(xfer_b)
  );

  generate
    if (HAS_E) begin : g_pair_e
      logic hit_e, xfer_e;
      pwmbt_buf_pair #(.CNT_W(CNT_W)) u_pair_e (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt(cnt_q),
        .clear_evt(clear_evt), .pwm_mode(ctrl_q[CTRL_PWM]),
        .buf_en(ctrl_q[CTRL_BUFE]), .sel_clear(xmode_q[XM_SELE]),
        .wr_cmp(wr_cmpe), .wr_buf(wr_bufe), .wr_data(wr_data),
        .cmp_q(cmp_e), .buf_q(buf_e), .hit(hit_e), .xfer(xfer_e)
      );
      assert_e_match_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CTRL_BUFE] && !xmode_q[XM_SELE] && hit_e) |=> (cmp_e == $past(buf_e)));
      assert_e_xfer_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_e |-> cnt_en);
    end else begin : g_no_e
      assign cmp_e = '0;
      assign buf_e = '0;
      assert_no_e_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_xmode |=> !xmode_q[XM_SELE]);
    end
  endgenerate

  pwmbt_wave #(.CNT_W(CNT_W)) u_wave (
    .clk(clk), .rst_n(rst_n), .pwm_mode(ctrl_q[CTRL_PWM]),
    .clear_evt(clear_evt), .hit_b(hit_b), .xfer_b(xfer_b),
    .cmp_b(cmp_b), .buf_b(buf_b), .pwm_q(pwm_out)
  );

  assign cmp_flag = hit_b;

  always_comb begin
    rd_data = '0;
    case (reg_addr_e'(rd_addr))
      RA_CNT:   rd_data = cnt_q;
      RA_PER:   rd_data = per_q;
      RA_CMPB:  rd_data = cmp_b;
      RA_BUFB:  rd_data = buf_b;
      RA_CMPE:  rd_data = cmp_e;
      RA_BUFE:  rd_data = buf_e;
      RA_CTRL:  rd_data[2:0] = ctrl_q;
      RA_XMODE: rd_data[7:0] = xmode_q;
      default:  rd_data = '0;
    endcase
  end

  assert_xmode_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_xmode |=> (xmode_q[7:3] == '0));
  assert_b_gated_by_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_b |-> cnt_en);
endmodule

// File: tb/pwm_buf_timer_tb.sv
module pwm_buf_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0] per;
    logic [15:0] cmp;
    logic [15:0] hi;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{16'd9,  16'd0,  16'd0},
    '{16'd9,  16'd1,  16'd2},
    '{16'd9,  16'd4,  16'd5},
    '{16'd9,  16'd8,  16'd9},
    '{16'd9,  16'd9,  16'd10},
    '{16'd9,  16'd12, 16'd10},
    '{16'd3,  16'd2,  16'd3},
    '{16'd15, 16'd7,  16'd8}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data, rd_data_ne;
  logic        pwm_out, pwm_ne, cmp_flag, flag_ne;
  logic        flag_s;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_buf_timer #(.CNT_W(16), .HAS_E(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .pwm_out(pwm_out), .cmp_flag(cmp_flag)
  );

  pwm_buf_timer #(.CNT_W(16), .HAS_E(1'b0)) dut_ne (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data_ne), .pwm_out(pwm_ne), .cmp_flag(flag_ne)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rd_addr = a; #1;
    d = rd_data;
  endtask

  task automatic tick();
    cnt_en = 1'b1; #1;
    flag_s = cmp_flag;
    @(posedge clk); #1;
    cnt_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int hi;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    rd(3'd0, v); chk("R1 cnt", v, 16'h0);
    rd(3'd1, v); chk("R1 per", v, 16'hFFFF);
    rd(3'd2, v); chk("R1 cmpB", v, 16'hFFFF);
    rd(3'd3, v); chk("R1 bufD", v, 16'hFFFF);
    rd(3'd6, v); chk("R1 ctrl", v, 16'h0);
    rd(3'd7, v); chk("R1 xmode", v, 16'h0);
    chk("R1 pwm", {15'd0, pwm_out}, 16'h0);

    // R2 / R3 reserved bits and reduced variant
    wr(3'd7, 16'hFFFF);
    rd(3'd7, v); chk("R2 xmode readback", v, 16'h0006);
    chk("R3 xmode no E", rd_data_ne, 16'h0002);
    wr(3'd7, 16'h0000);
    wr(3'd4, 16'h1234);
    rd(3'd4, v); chk("R7 cmpE direct", v, 16'h1234);
    chk("R3 cmpE absent", rd_data_ne, 16'h0);

    // R4 counter
    wr(3'd1, 16'd3);
    wr(3'd0, 16'd0);
    repeat (3) @(posedge clk); #1;
    rd(3'd0, v); chk("R4 hold", v, 16'd0);
    tick(); tick(); tick();
    rd(3'd0, v); chk("R4 count", v, 16'd3);
    tick();
    rd(3'd0, v); chk("R4 wrap", v, 16'd0);

    // R9 write routing
    wr(3'd1, 16'd99);
    wr(3'd6, 16'h0001);
    wr(3'd2, 16'd20);
    rd(3'd2, v); chk("R9 direct cmpB", v, 16'd20);
    wr(3'd6, 16'h0003);
    wr(3'd2, 16'd30);
    rd(3'd2, v); chk("R9 cmpB kept", v, 16'd20);
    rd(3'd3, v); chk("R9 redirected to bufD", v, 16'd30);

    // R5 transfer on match, R12 flag
    wr(3'd0, 16'd18);
    tick();
    tick(); chk("R12 flag low off match", {15'd0, flag_s}, 16'h0);
    rd(3'd2, v); chk("R5 before match", v, 16'd20);
    tick(); chk("R12 flag at match", {15'd0, flag_s}, 16'h1);
    rd(3'd2, v); chk("R5 loaded on match", v, 16'd30);

    // R6 transfer on clear
    wr(3'd7, 16'h0002);
    wr(3'd3, 16'd40);
    wr(3'd0, 16'd29);
    tick(); tick();
    rd(3'd2, v); chk("R6 held through match", v, 16'd30);
    wr(3'd0, 16'd99);
    tick();
    rd(3'd2, v); chk("R6 loaded on clear", v, 16'd40);
    rd(3'd0, v); chk("R4 cleared", v, 16'd0);

    // R8 non-PWM fallback
    wr(3'd6, 16'h0002);
    wr(3'd3, 16'd50);
    wr(3'd0, 16'd40);
    tick();
    rd(3'd2, v); chk("R8 match timing outside PWM", v, 16'd50);
    chk("R11 low outside PWM", {15'd0, pwm_out}, 16'h0);

    // R7 E pair
    wr(3'd6, 16'h0001);
    wr(3'd4, 16'd10);
    wr(3'd6, 16'h0005);
    wr(3'd7, 16'h0004);
    wr(3'd5, 16'd60);
    wr(3'd0, 16'd10);
    tick();
    rd(3'd4, v); chk("R7 E held through match", v, 16'd10);
    wr(3'd0, 16'd99);
    tick();
    rd(3'd4, v); chk("R7 E loaded on clear", v, 16'd60);
    wr(3'd7, 16'h0000);
    wr(3'd5, 16'd70);
    wr(3'd0, 16'd60);
    tick();
    rd(3'd4, v); chk("R7 E loaded on match", v, 16'd70);

    // R10 write and transfer together
    wr(3'd6, 16'h0003);
    wr(3'd3, 16'd80);
    wr(3'd0, 16'd50);
    wr_en = 1'b1; wr_addr = 3'd3; wr_data = 16'd90; cnt_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0; cnt_en = 1'b0;
    rd(3'd2, v); chk("R10 compare gets old buffer", v, 16'd80);
    rd(3'd3, v); chk("R10 buffer keeps new write", v, 16'd90);

    // R11 duty table
    for (int i = 0; i < 8; i++) begin
      wr(3'd6, 16'h0001);
      wr(3'd1, VECS[i].per);
      wr(3'd2, VECS[i].cmp);
      wr(3'd0, 16'd0);
      cnt_en = 1'b1;
      repeat (2 * (int'(VECS[i].per) + 1)) @(posedge clk);
      #1;
      hi = 0;
      for (int k = 0; k <= int'(VECS[i].per); k++) begin
        @(posedge clk); #1;
        hi += int'(pwm_out);
      end
      cnt_en = 1'b0;
      chk($sformatf("R11 duty per=%0d cmp=%0d", VECS[i].per, VECS[i].cmp),
          16'(hi), VECS[i].hi);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule